// File: doc/BRIEF.md
# DDR Byte-Lane Read Capture and Resynchronisation

This block sits on the receive side of a wide DDR read data path. The bus is split into byte lanes. Each lane has its own data strobe, which travels with the read data, and the lane's data is sampled on both edges of that strobe. Each lane therefore produces one 16-bit pair per strobe cycle: the byte seen at the rising edge and the byte seen at the falling edge.

Every lane writes its pairs into its own small asynchronous FIFO. The FIFO's write side is clocked by the lane's strobe and its read side by the controller clock. Lanes with different board delays can therefore arrive at different times and still line up once they are in the controller domain. When every lane holds at least one pair, the block pops one pair from each lane in the same cycle and presents the joined word with a one-cycle valid.

A read-enable window, driven by the controller, marks the strobe cycles that carry data. Strobe toggling outside the window, such as preamble and postamble, writes nothing. The data-mask bit of each lane carries nothing on reads and is not an input of this block.

Top module: `ddr_lane_rx`

## Requirements
- R1: In output lane slice `out_data[16*l+15:16*l]`, bits [7:0] hold the byte sampled on the rising strobe edge and bits [15:8] hold the byte sampled on the following falling edge.
- R2: Each lane is sampled only by its own strobe bit `dqs[l]`. Lanes whose strobes are skewed against each other by up to several nanoseconds still combine into the correct word.
- R3: `out_valid` is high for exactly one controller cycle per word. A word is emitted only when every lane FIFO holds a pair, and one pair is then removed from every lane together.
- R4: A strobe edge is ignored when `rd_window` is low at that rising edge or at the falling edge that completes the pair. Preamble and postamble toggling produces no output word.
- R5: If a pair completes while that lane's FIFO is full, the pair is dropped and `overflow[l]` is set. The flag stays set until reset.
- R6: While `rst_n` is low, `out_valid` is 0, `overflow` is all zeros and every FIFO is empty.
- R7: When the FIFO depth is not exceeded, words come out in the order the strobe cycles delivered them, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| rd_window | input | 1 | High during strobe cycles that carry read data |
| dqs | input | LANES | One data strobe per byte lane |
| dq | input | LANES*LANE_W | Read data, lane l at bits [LANE_W*l +: LANE_W] |
| out_valid | output | 1 | One-cycle pulse marking a joined word |
| out_data | output | 2*LANES*LANE_W | Joined word, lane l at bits [2*LANE_W*l +: 2*LANE_W] |
| overflow | output | LANES | Sticky per-lane FIFO overflow flags |

## Verification
The bench uses the default parameters: eight lanes of eight bits and FIFOs eight pairs deep.

With these values it can apply random per-lane skews of 0 to 3 ns against a 10 ns strobe. That exercises the per-lane resync while keeping every burst well inside the FIFO depth, and it adds a deliberate lane-staircase skew.

Pausing the controller clock and sending DEPTH+1 pairs right after reset fills the FIFOs exactly. This reaches the full boundary, the dropped pair, and stickiness of the flag across a later burst.

// File: rtl/ddr_lane_rx.sv
module ddr_lane_rx #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_window,
  input  logic [LANES-1:0]          dqs,
  input  logic [LANES*LANE_W-1:0]   dq,
  output logic                      out_valid,
  output logic [2*LANES*LANE_W-1:0] out_data,
  output logic [LANES-1:0]          overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int WW = 2 * LANE_W;

  logic [LANES-1:0]          lane_ne;
  logic [2*LANES*LANE_W-1:0] heads;
  wire                       pop = &lane_ne;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] rise_q;
    logic              rise_ok;
    logic              ovf;
    logic [WW-1:0]     mem [DEPTH];
    logic [PW-1:0]     wbin, wgray, rg_s1, rg_s2;
    logic [PW-1:0]     rbin, rgray, wg_s1, wg_s2;

    wire [LANE_W-1:0] dq_l   = dq[l*LANE_W +: LANE_W];
    wire              wr_req = rd_window & rise_ok;
    // full: top two Gray bits inverted, rest equal (needs DEPTH >= 4)
    wire full = (wgray == {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]});
    wire [PW-1:0] wbin_nx = wbin + 1'b1;
    wire [PW-1:0] rbin_nx = rbin + 1'b1;

    always_ff @(posedge dqs[l] or negedge rst_n)
      if (!rst_n) begin
        rise_ok <= 1'b0;
        rise_q  <= '0;
      end else begin
        rise_ok <= rd_window;
        rise_q  <= dq_l;
      end

    always_ff @(negedge dqs[l] or negedge rst_n)
      if (!rst_n) begin
        wbin  <= '0;
        wgray <= '0;
        rg_s1 <= '0;
        rg_s2 <= '0;
        ovf   <= 1'b0;
      end else begin
        rg_s1 <= rgray;
        rg_s2 <= rg_s1;
        if (wr_req) begin
          if (full) ovf <= 1'b1;
          else begin
            wbin  <= wbin_nx;
            wgray <= bin2gray(wbin_nx);
          end
        end
      end

    always_ff @(negedge dqs[l])
      if (wr_req && !full) mem[wbin[AW-1:0]] <= {dq_l, rise_q};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rbin  <= '0;
        rgray <= '0;
        wg_s1 <= '0;
        wg_s2 <= '0;
      end else begin
        wg_s1 <= wgray;
        wg_s2 <= wg_s1;
        if (pop) begin
          rbin  <= rbin_nx;
          rgray <= bin2gray(rbin_nx);
        end
      end

    assign lane_ne[l]             = (rgray != wg_s2);
    assign heads[l*WW +: WW]      = mem[rbin[AW-1:0]];
    assign overflow[l]            = ovf;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pop;
      if (pop) out_data <= heads;
    end
endmodule

module ddr_lane_rx_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic [LANES-1:0] lane_ne,
  input logic [LANES-1:0] overflow
);
  always @(posedge clk)
    if (!rst_n) assert_reset_clear_R6: assert (!out_valid && overflow == '0);

  assert_valid_needs_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(&lane_ne));

  assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow & $past(overflow)) == $past(overflow));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_empty_only_by_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lane_ne[i]) |-> $past(&lane_ne));
  end
endmodule

bind ddr_lane_rx ddr_lane_rx_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid),
  .lane_ne(lane_ne), .overflow(overflow)
);

// File: tb/sim_ddr_lane_rx.sv
module sim_ddr_lane_rx;
  localparam int CLK_P  = 4;
  localparam int LANES  = 8;
  localparam int LANE_W = 8;
  localparam int DEPTH  = 8;
  localparam int NW     = 256;
  localparam int DW     = 2 * LANES * LANE_W;

  logic clk = 1'b0, clk_en = 1'b1, rst_n = 1'b1, rd_window = 1'b0;
  logic [LANES-1:0] dqs = '0;
  logic [LANES*LANE_W-1:0] dq = '0;
  logic out_valid;
  logic [DW-1:0] out_data;
  logic [LANES-1:0] overflow;

  logic [DW-1:0] exp_w [NW];
  int wr_n = 0, rd_n = 0, checks = 0, fails = 0;
  bit done = 0;

  ddr_lane_rx #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_window(rd_window), .dqs(dqs), .dq(dq),
    .out_valid(out_valid), .out_data(out_data), .overflow(overflow));

  always #(CLK_P/2) clk = clk_en ? ~clk : 1'b0;

  function automatic logic [DW-1:0] rand_word();
    logic [DW-1:0] w;
    for (int i = 0; i < DW/32; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  function automatic logic [DW-1:0] ramp_word(input int k);
    logic [DW-1:0] w;
    for (int l = 0; l < LANES; l++) begin
      w[l*16 +: 8]     = 8'(8'h10 + l + k);
      w[l*16 + 8 +: 8] = 8'(8'h80 + l + k);
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // R1 R2 R3 R7: each emitted word must equal the next expected word
  always @(negedge clk)
    if (rst_n && out_valid) begin
      check(out_data == exp_w[rd_n], "R1/R2/R7 word order/layout", out_data, exp_w[rd_n]);
      rd_n++;
    end

  task automatic idle_toggle(input int cyc);
    for (int c = 0; c < cyc; c++) begin
      dq = {$urandom, $urandom};
      #2 dqs = '1;
      #5 dqs = '0;
      #3;
    end
  endtask

  task automatic lane_run(input int l, input int base, input int n, input int sk);
    #(sk);
    for (int k = 0; k < n; k++) begin
      dq[l*LANE_W +: LANE_W] = exp_w[base+k][l*16 +: 8];
      #2 dqs[l] = 1'b1;
      #3 dq[l*LANE_W +: LANE_W] = exp_w[base+k][l*16 + 8 +: 8];
      #2 dqs[l] = 1'b0;
      #3;
    end
  endtask

  task automatic burst(input int n, input int mode);
    int base;
    base = wr_n;
    idle_toggle(3);
    rd_window = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      automatic int ll = l;
      automatic int sk = (mode == 0) ? 0 : (mode == 1) ? $urandom_range(3, 0) : ll % 4;
      fork lane_run(ll, base, n, sk); join_none
    end
    wait fork;
    #2 rd_window = 1'b0;
    wr_n += n;
    idle_toggle(2);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #9 rst_n = 1'b1;
    rd_n = wr_n;
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd20240611);
    for (int i = 0; i < NW; i++) exp_w[i] = rand_word();
    for (int i = 0; i < 4; i++) exp_w[i] = ramp_word(i);
    #1 do_reset();
    @(negedge clk);
    // R6: outputs idle after reset
    check(!out_valid && overflow == '0, "R6 reset state", DW'({out_valid, overflow}), '0);

    // R4: pure strobe toggling with closed window writes nothing
    idle_toggle(6);
    repeat (10) @(negedge clk);
    check(rd_n == wr_n, "R4 closed-window edges ignored", DW'(rd_n), DW'(wr_n));

    // R1: known ramp pattern, aligned lanes
    burst(4, 0);
    repeat (10) @(negedge clk);
    check(rd_n == wr_n, "R1 ramp words delivered", DW'(rd_n), DW'(wr_n));

    // R2: staircase skew across lanes, single-word burst
    burst(1, 2);
    burst(5, 2);
    repeat (10) @(negedge clk);
    check(rd_n == wr_n, "R2 skewed lanes joined", DW'(rd_n), DW'(wr_n));

    // R3 R7: random lengths and skews
    for (int b = 0; b < 12; b++) begin
      burst($urandom_range(6, 1), 1);
      repeat (8) @(negedge clk);
      check(rd_n == wr_n, "R3/R7 word count", DW'(rd_n), DW'(wr_n));
    end
    check(overflow == '0, "R5 no overflow within depth", DW'(overflow), '0);

    // R5: fill with controller clock stopped, one pair too many
    do_reset();
    clk_en = 1'b0;
    burst(DEPTH + 1, 1);
    check(overflow == '1, "R5 overflow set on all lanes", DW'(overflow), DW'({LANES{1'b1}}));
    clk_en = 1'b1;
    repeat (40) @(negedge clk);
    check(rd_n == wr_n - 1, "R5 dropped pair not emitted", DW'(rd_n), DW'(wr_n - 1));
    rd_n = wr_n;
    burst(3, 1);
    repeat (10) @(negedge clk);
    check(rd_n == wr_n, "R5 later burst still delivered", DW'(rd_n), DW'(wr_n));
    check(overflow == '1, "R5 overflow sticky", DW'(overflow), DW'({LANES{1'b1}}));

    // R6: reset clears sticky flags
    do_reset();
    @(negedge clk);
    check(overflow == '0 && !out_valid, "R6 reset clears overflow", DW'(overflow), '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule